// File: doc/BRIEF.md
# Bus Cycle Termination Controller

This block runs one external bus cycle at a time from the master side. It takes a request made of an address and a direction. It asserts an address strobe and holds the address and direction steady. It then watches three termination inputs that change only on the rising clock edge: data acknowledge, bus error and halt. An input is asserted when it is 1. How the cycle ends depends on which inputs are seen, and the block looks at them on two consecutive sampling edges. The first edge is the one where acknowledge or bus error is first seen. The second edge is the next rising edge.

There are four outcomes:
- **Normal completion.**
- **Completion followed by a bus stall.** This happens when halt joins acknowledge.
- **Bus error exception request.**
- **Retry of the same access.** This happens when bus error and halt are seen together.

The outcome appears as a single-clock status pulse. A retry re-presents the saved address and direction without a new request, once halt is released. No new cycle starts while any termination input is still asserted from the previous one. An early acknowledge cannot cut that cycle short.

An internal bus monitor can be given a non-zero clock limit. It then raises an internal bus error for a cycle that gets no acknowledge or bus error.

Top module: `bus_term_ctrl`

## Requirements
- R1: After reset, `strobe_o` and all four status pulses are 0 and `req_ready` is 1 while the three termination inputs are 0.
- R2: Each status pulse (`done_o`, `halted_o`, `berr_o`, `retry_o`) lasts exactly one clock. `strobe_o` is 0 in that clock.
- R3: A cycle whose two sampling edges show acknowledge and no bus error or halt ends with `done_o`=1 and the other three pulses 0. The pulse appears after the second sampling edge.
- R4: If halt is seen on either sampling edge together with acknowledge and no bus error, the cycle ends with `done_o`=1 and `halted_o`=1. No new cycle begins until halt returns to 0.
- R5: If bus error is seen on either sampling edge and halt on neither, the cycle ends with only `berr_o`=1. This holds whether or not acknowledge is asserted, including when acknowledge and bus error arrive on the same edge.
- R6: If bus error and halt are both seen across the two sampling edges, the cycle ends with only `retry_o`=1. Once all inputs are 0, the strobe is asserted again with the saved address and direction and no new request.
- R7: Halt alone while the strobe is asserted does not end the cycle. The first sampling edge is the first one with acknowledge, bus error or monitor expiry.
- R8: After a cycle ends, `req_ready` stays 0 and no strobe is asserted while acknowledge, bus error or halt is 1.
- R9: With `mon_limit`=L≠0, a cycle that sees neither acknowledge nor bus error for L clocks of asserted strobe takes an internal bus error at that L-th edge as its first sampling edge. With halt also asserted, the outcome is a retry.
- R10: With `mon_limit`=0, the bus monitor never fires and a cycle waits for termination without limit.
- R11: While `strobe_o` is 1, `bus_addr_o` and `bus_write_o` equal the accepted request and do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Cycle request present |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | Request direction, 1 = write |
| req_ready | output | 1 | Request accepted at this edge when valid |
| ack_i | input | 1 | Data acknowledge, 1 = asserted |
| berr_i | input | 1 | Bus error, 1 = asserted |
| halt_i | input | 1 | Halt, 1 = asserted |
| mon_limit | input | MON_W | Bus monitor limit in clocks, 0 disables |
| strobe_o | output | 1 | Address strobe, 1 = asserted |
| bus_addr_o | output | ADDR_W | Address of the current cycle |
| bus_write_o | output | 1 | Direction of the current cycle |
| done_o | output | 1 | Pulse: cycle completed with data transfer |
| halted_o | output | 1 | Pulse: completion followed by a bus stall |
| berr_o | output | 1 | Pulse: bus error exception request |
| retry_o | output | 1 | Pulse: retry scheduled |

## Verification
Bus monitor expiry and an external halt can coincide on the same sampling edge. To provoke this, the bench asserts halt during a cycle that is otherwise left unterminated until the limit runs out. The expected result is a retry pulse rather than a bus error, followed by a strobe re-assertion with the old address once halt drops. Acknowledge and bus error arriving on the same edge are judged the same way, and the bus error must win.

// File: rtl/bus_term_pkg.sv
package bus_term_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_CONFIRM = 2'd2,
        ST_RELEASE = 2'd3
    } bt_state_e;

    typedef struct packed {
        logic done;
        logic halted;
        logic berr;
        logic retry;
    } bt_result_t;

endpackage

// File: rtl/bt_classify.sv
module bt_classify
    import bus_term_pkg::*;
(
    input  logic       berr_seen,
    input  logic       halt_seen,
    output bt_result_t res
);
    always_comb begin
        res = '0;
        if (berr_seen && halt_seen) begin
            res.retry = 1'b1;
        end else if (berr_seen) begin
            res.berr = 1'b1;
        end else if (halt_seen) begin
            res.done   = 1'b1;
            res.halted = 1'b1;
        end else begin
            res.done = 1'b1;
        end
    end
endmodule

// File: rtl/bt_monitor.sv
module bt_monitor #(
    parameter int MON_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic [MON_W-1:0] limit,
    output logic             expire
);
    logic [MON_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = count_en && (limit != '0) && (cnt_q == limit - MON_W'(1));
        if (!count_en || expire) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + MON_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/bus_term_ctrl.sv
module bus_term_ctrl
    import bus_term_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int MON_W   = 8,
    parameter bit USE_MON = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              req_ready,
    input  logic              ack_i,
    input  logic              berr_i,
    input  logic              halt_i,
    input  logic [MON_W-1:0]  mon_limit,
    output logic              strobe_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              bus_write_o,
    output logic              done_o,
    output logic              halted_o,
    output logic              berr_o,
    output logic              retry_o
);
    typedef struct packed {
        bt_state_e         st;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic              berr_n;
        logic              halt_n;
        logic              retry_pend;
        bt_result_t        res;
    } regs_t;

    regs_t      r_d, r_q;
    bt_result_t cls_res;
    logic       tmo;
    logic       lines_clear;
    logic       mon_count;

    assign lines_clear = !ack_i && !berr_i && !halt_i;
    assign mon_count   = (r_q.st == ST_ACTIVE) && !ack_i && !berr_i;

    generate
        if (USE_MON) begin : g_mon
            bt_monitor #(.MON_W(MON_W)) u_mon (
                .clk      (clk),
                .rst_n    (rst_n),
                .count_en (mon_count),
                .limit    (mon_limit),
                .expire   (tmo)
            );
        end else begin : g_nomon
            assign tmo = 1'b0;
        end
    endgenerate

    bt_classify u_cls (
        .berr_seen (r_q.berr_n | berr_i),
        .halt_seen (r_q.halt_n | halt_i),
        .res       (cls_res)
    );

    always_comb begin
        r_d     = r_q;
        r_d.res = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid && lines_clear) begin
                    r_d.addr = req_addr;
                    r_d.wr   = req_write;
                    r_d.st   = ST_ACTIVE;
                end
            end
            ST_ACTIVE: begin
                if (ack_i || berr_i || tmo) begin
                    r_d.berr_n = berr_i | tmo;
                    r_d.halt_n = halt_i;
                    r_d.st     = ST_CONFIRM;
                end
            end
            ST_CONFIRM: begin
                r_d.res        = cls_res;
                r_d.retry_pend = cls_res.retry;
                r_d.berr_n     = 1'b0;
                r_d.halt_n     = 1'b0;
                r_d.st         = ST_RELEASE;
            end
            ST_RELEASE: begin
                if (lines_clear) begin
                    r_d.st         = r_q.retry_pend ? ST_ACTIVE : ST_IDLE;
                    r_d.retry_pend = 1'b0;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, addr: '0, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready   = (r_q.st == ST_IDLE) && lines_clear;
    assign strobe_o    = (r_q.st == ST_ACTIVE) || (r_q.st == ST_CONFIRM);
    assign bus_addr_o  = r_q.addr;
    assign bus_write_o = r_q.wr;
    assign done_o      = r_q.res.done;
    assign halted_o    = r_q.res.halted;
    assign berr_o      = r_q.res.berr;
    assign retry_o     = r_q.res.retry;
endmodule

// File: rtl/bus_term_chk.sv
module bus_term_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_i,
    input logic              berr_i,
    input logic              halt_i,
    input logic              strobe_o,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic              bus_write_o,
    input logic              done_o,
    input logic              halted_o,
    input logic              berr_o,
    input logic              retry_o
);
    a_r2_done_one_clk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r2_berr_one_clk: assert property (@(posedge clk) disable iff (!rst_n)
        berr_o |=> !berr_o);
    a_r2_strobe_off_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || berr_o || retry_o) |-> !strobe_o);
    a_r4_halt_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> done_o);
    a_r6_retry_alone: assert property (@(posedge clk) disable iff (!rst_n)
        retry_o |-> (!done_o && !berr_o && !halted_o));
    a_r5_berr_alone: assert property (@(posedge clk) disable iff (!rst_n)
        berr_o |-> (!done_o && !retry_o));
    a_r6_retry_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_o && !ack_i && !berr_i && !halt_i) |=> strobe_o);
    a_r8_clear_before_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_o) |-> ($past(!ack_i) && $past(!berr_i) && $past(!halt_i)));
    a_r11_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o && $past(strobe_o)) |-> ($stable(bus_addr_o) && $stable(bus_write_o)));
endmodule

bind bus_term_ctrl bus_term_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_i       (ack_i),
    .berr_i      (berr_i),
    .halt_i      (halt_i),
    .strobe_o    (strobe_o),
    .bus_addr_o  (bus_addr_o),
    .bus_write_o (bus_write_o),
    .done_o      (done_o),
    .halted_o    (halted_o),
    .berr_o      (berr_o),
    .retry_o     (retry_o)
);

// File: tb/sim_bus_term_ctrl.sv
module sim_bus_term_ctrl;
    localparam int AW = 24;
    localparam int MW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_write = 1'b0;
    logic          req_ready;
    logic          ack_i = 1'b0, berr_i = 1'b0, halt_i = 1'b0;
    logic [MW-1:0] mon_limit = '0;
    logic          strobe_o;
    logic [AW-1:0] bus_addr_o;
    logic          bus_write_o;
    logic          done_o, halted_o, berr_o, retry_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    bus_term_ctrl #(.ADDR_W(AW), .MON_W(MW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_ready(req_ready), .ack_i(ack_i), .berr_i(berr_i),
        .halt_i(halt_i), .mon_limit(mon_limit), .strobe_o(strobe_o),
        .bus_addr_o(bus_addr_o), .bus_write_o(bus_write_o), .done_o(done_o),
        .halted_o(halted_o), .berr_o(berr_o), .retry_o(retry_o)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_lines(input logic a, input logic b, input logic h);
        ack_i = a; berr_i = b; halt_i = h;
    endtask

    task automatic start_cycle(input string tag, input logic [AW-1:0] a, input logic w);
        req_valid = 1'b1; req_addr = a; req_write = w;
        tick();
        req_valid = 1'b0;
        chk({tag, " R11 strobe"}, 32'(strobe_o), 32'd1);
        chk({tag, " R11 addr"}, 32'(bus_addr_o), 32'(a));
        chk({tag, " R11 dir"}, 32'(bus_write_o), 32'(w));
    endtask

    task automatic expect_res(input string tag, input logic d, input logic h,
                              input logic b, input logic r);
        chk({tag, " done"}, 32'(done_o), 32'(d));
        chk({tag, " halted"}, 32'(halted_o), 32'(h));
        chk({tag, " berr"}, 32'(berr_o), 32'(b));
        chk({tag, " retry"}, 32'(retry_o), 32'(r));
        chk({tag, " R2 strobe low"}, 32'(strobe_o), 32'd0);
    endtask

    task automatic terminate(input logic a1, input logic b1, input logic h1,
                             input logic a2, input logic b2, input logic h2);
        set_lines(a1, b1, h1);
        tick();
        set_lines(a2, b2, h2);
        tick();
    endtask

    task automatic release_all(input string tag);
        set_lines(1'b0, 1'b0, 1'b0);
        tick();
        chk({tag, " R2 pulses gone"}, 32'({done_o, halted_o, berr_o, retry_o}), 32'd0);
    endtask

    task automatic t_reset();
        chk("R1 strobe", 32'(strobe_o), 32'd0);
        chk("R1 pulses", 32'({done_o, halted_o, berr_o, retry_o}), 32'd0);
        chk("R1 ready", 32'(req_ready), 32'd1);
    endtask

    task automatic t_normal();
        start_cycle("R3 normal", 24'h00_1234, 1'b0);
        terminate(1, 0, 0, 1, 0, 0);
        expect_res("R3 normal", 1, 0, 0, 0);
        release_all("R3 normal");
        tick();
        chk("R3 back idle ready", 32'(req_ready), 32'd1);
    endtask

    task automatic t_halt_stall();
        start_cycle("R4 halt", 24'h00_2000, 1'b1);
        terminate(1, 0, 1, 1, 0, 1);
        expect_res("R4 halt", 1, 1, 0, 0);
        ack_i = 1'b0;
        req_valid = 1'b1; req_addr = 24'h00_3000; req_write = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R4 stalled strobe", 32'(strobe_o), 32'd0);
            chk("R8 stalled ready", 32'(req_ready), 32'd0);
        end
        halt_i = 1'b0;
        tick();
        chk("R4 still idle", 32'(strobe_o), 32'd0);
        tick();
        req_valid = 1'b0;
        chk("R4 next strobe", 32'(strobe_o), 32'd1);
        chk("R4 next addr", 32'(bus_addr_o), 32'h3000);
        terminate(1, 0, 0, 1, 0, 0);
        expect_res("R3 after halt", 1, 0, 0, 0);
        release_all("R4 tail");
        tick();
    endtask

    task automatic t_berr();
        start_cycle("R5 berr only", 24'h00_4000, 1'b0);
        terminate(0, 1, 0, 0, 1, 0);
        expect_res("R5 berr only", 0, 0, 1, 0);
        release_all("R5 a"); tick();
        start_cycle("R5 ack+berr", 24'h00_4004, 1'b1);
        terminate(1, 1, 0, 1, 1, 0);
        expect_res("R5 ack+berr same edge", 0, 0, 1, 0);
        release_all("R5 b"); tick();
        start_cycle("R5 late berr", 24'h00_4008, 1'b0);
        terminate(1, 0, 0, 1, 1, 0);
        expect_res("R5 berr at second edge", 0, 0, 1, 0);
        release_all("R5 c"); tick();
    endtask

    task automatic t_retry();
        start_cycle("R6 retry", 24'h00_5550, 1'b1);
        terminate(0, 1, 1, 0, 1, 1);
        expect_res("R6 retry", 0, 0, 0, 1);
        berr_i = 1'b0;
        for (int i = 0; i < 2; i++) begin
            tick();
            chk("R6 held by halt", 32'(strobe_o), 32'd0);
        end
        halt_i = 1'b0;
        tick();
        chk("R6 re-strobe", 32'(strobe_o), 32'd1);
        chk("R6 same addr", 32'(bus_addr_o), 32'h5550);
        chk("R6 same dir", 32'(bus_write_o), 32'd1);
        terminate(1, 0, 0, 1, 0, 0);
        expect_res("R6 retried ok", 1, 0, 0, 0);
        release_all("R6 tail"); tick();
    endtask

    task automatic t_late_halt();
        start_cycle("R4 late halt", 24'h00_6000, 1'b0);
        terminate(1, 0, 0, 1, 0, 1);
        expect_res("R4 halt at second edge", 1, 1, 0, 0);
        release_all("R4 late"); tick();
        start_cycle("R7 halt first", 24'h00_6100, 1'b0);
        halt_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R7 halt alone no end strobe", 32'(strobe_o), 32'd1);
            chk("R7 halt alone no pulse", 32'({done_o, halted_o, berr_o, retry_o}), 32'd0);
        end
        terminate(1, 0, 1, 1, 0, 1);
        expect_res("R7 halt then ack", 1, 1, 0, 0);
        release_all("R7"); tick();
    endtask

    task automatic t_linger();
        start_cycle("R8 linger", 24'h00_7000, 1'b0);
        terminate(1, 0, 0, 1, 0, 0);
        expect_res("R8 linger", 1, 0, 0, 0);
        req_valid = 1'b1; req_addr = 24'h00_7100;
        for (int i = 0; i < 2; i++) begin
            tick();
            chk("R8 ack held strobe", 32'(strobe_o), 32'd0);
            chk("R8 ack held ready", 32'(req_ready), 32'd0);
        end
        ack_i = 1'b0;
        tick();
        tick();
        req_valid = 1'b0;
        chk("R8 starts after release", 32'(strobe_o), 32'd1);
        terminate(1, 0, 0, 1, 0, 0);
        release_all("R8"); tick();
    endtask

    task automatic t_monitor();
        mon_limit = 8'd4;
        start_cycle("R9 timeout", 24'h00_8000, 1'b0);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R9 still strobed", 32'(strobe_o), 32'd1);
        end
        tick();
        expect_res("R9 timeout berr", 0, 0, 1, 0);
        release_all("R9 a"); tick();
        start_cycle("R9 timeout+halt", 24'h00_8100, 1'b1);
        halt_i = 1'b1;
        for (int i = 0; i < 4; i++) tick();
        chk("R9 no pulse yet", 32'({done_o, halted_o, berr_o, retry_o}), 32'd0);
        tick();
        expect_res("R9 timeout with halt", 0, 0, 0, 1);
        halt_i = 1'b0;
        tick();
        chk("R9 retry re-strobe addr", 32'(bus_addr_o), 32'h8100);
        chk("R9 retry re-strobe", 32'(strobe_o), 32'd1);
        terminate(1, 0, 0, 1, 0, 0);
        expect_res("R9 retry done", 1, 0, 0, 0);
        release_all("R9 b"); tick();
        mon_limit = 8'd0;
        start_cycle("R10 disabled", 24'h00_9000, 1'b0);
        for (int i = 0; i < 20; i++) tick();
        chk("R10 no timeout strobe", 32'(strobe_o), 32'd1);
        chk("R10 no timeout pulse", 32'(berr_o), 32'd0);
        terminate(1, 0, 0, 1, 0, 0);
        expect_res("R10 normal end", 1, 0, 0, 0);
        release_all("R10"); tick();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_halt_stall();
        t_berr();
        t_retry();
        t_late_halt();
        t_linger();
        t_monitor();
        finish_run();
    end

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule